// File: doc/BRIEF.md
# SPI-Mode Memory Card Single-Block Data Mover

This block carries one data block between a byte stream and a memory card operating in SPI mode, once the card has already accepted the command that opens the transfer. It drives the serial clock and the host-to-card data line, and samples the card-to-host data line. A one-cycle `start` with `write_mode` and `blk_len` launches a transfer. The block reports completion with a one-cycle `done` pulse and a two-bit `status`.

On a read, the block polls the card for the start token. It then hands each payload byte to a valid/ready output stream and clocks three trailing bytes that it discards. On a write, it sends an idle byte and the start token. It then sends the payload bytes taken from a valid/ready input stream, followed by three zero bytes. After that it polls the card until the card releases its busy indication. Payload bytes move at a fast serial rate. Every other byte uses a slow rate.

Top module: `sd_spi_block_mover`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `sclk`, `rd_valid` and `wr_ready` are 0, `mosi` is 1 and `status` is 0.
- R2: On a read, the block clocks in bytes while they equal 0xFF. The first other byte, if it is 0xFE, starts the payload. The payload bytes then appear on `rd_data` in card order, each accepted once by `rd_valid`&`rd_ready`.
- R3: If POLL_LIMIT bytes in a row are all 0xFF while waiting for the read start token, the transfer ends with `status` = 1 (timeout). A token arriving as the POLL_LIMIT-th byte is still accepted.
- R4: A waited-for read byte that is neither 0xFF nor 0xFE ends the transfer at once with `status` = 2 (token error). No payload is delivered.
- R5: After the last read payload byte, exactly three more bytes are clocked. Then `done` pulses for one cycle with `status` = 0.
- R6: While `rd_valid` is 1 and `rd_ready` is 0, `rd_data` holds, `rd_valid` stays 1 and `sclk` does not move.
- R7: A write puts on `mosi`, MSB first: 0xFF, 0xFE, the payload bytes in stream order, then three 0x00 bytes. `wr_ready` is high only while the block waits for the next payload byte.
- R8: After the write trailer, the block clocks bytes (sending 0xFF) until the card returns 0xFF. It then ends with `status` = 0.
- R9: If POLL_LIMIT busy-poll bytes all differ from 0xFF, the write ends with `status` = 1 (timeout).
- R10: Payload bytes use an `sclk` high time of FAST_HALF clock cycles. Token, trailer and poll bytes use SLOW_HALF cycles.
- R11: A start with `blk_len` = 0 gives `done` with `status` = 0 in the next cycle, with no `sclk` activity and without `busy`.
- R12: During a read, `mosi` stays 1 for every byte. Block lengths from 1 up to MAX_LEN (512 by default) are carried in full.
- R13: A `start` that arrives while `busy` is 1 is ignored. The running transfer completes unchanged, with a single `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle transfer launch (ignored while busy) |
| write_mode | input | 1 | 1 = write to card, 0 = read from card |
| blk_len | input | LEN_W | Block length in bytes, 0 to MAX_LEN |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | Read payload byte available |
| rd_ready | input | 1 | Consumer accepts read byte |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Producer offers write byte |
| wr_ready | output | 1 | Block accepts write byte |
| sclk | output | 1 | Serial clock to card, idle low |
| mosi | output | 1 | Host-to-card data, idle high |
| miso | input | 1 | Card-to-host data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 timeout, 2 token error; held until next done |

## Verification
The bench builds the block with FAST_HALF = 1, SLOW_HALF = 3 and POLL_LIMIT = 6, while keeping MAX_LEN = 512. The short poll limit brings both timeout outcomes, and the token that arrives exactly on the last allowed poll, within a few hundred cycles. The two distinct half-periods let the measured `sclk` high time show which bytes ran fast. A full 512-byte read still fits the run, so the largest length is covered as well.

// File: rtl/sd_spi_block_mover_pkg.sv
package sd_spi_block_mover_pkg;

  typedef enum logic [1:0] {
    XS_OK        = 2'd0,
    XS_TIMEOUT   = 2'd1,
    XS_TOKEN_ERR = 2'd2
  } xfer_status_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PRE,
    S_TOKEN,
    S_RDATA,
    S_RHOLD,
    S_WDATA,
    S_WSEND,
    S_TRAIL,
    S_BUSY
  } mover_state_e;

  localparam logic [7:0] BYTE_IDLE  = 8'hFF;
  localparam logic [7:0] BYTE_START = 8'hFE;
  localparam logic [7:0] BYTE_PAD   = 8'h00;
  localparam int         TRAIL_BYTES = 3;

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int FAST_HALF = 2,
  parameter int SLOW_HALF = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int MAXH = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
  localparam int CW   = $clog2(MAXH + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = fast ? CW'(FAST_HALF - 1) : CW'(SLOW_HALF - 1);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run)    cnt <= '0;
    else if (cnt == lim) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int FAST_HALF = 2,
  parameter int SLOW_HALF = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       fast,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);
  logic       fast_q;
  logic [7:0] tx_sh;
  logic [7:0] rx_sh;
  logic [2:0] bit_idx;
  logic       tick;

  spi_tick_gen #(.FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)) u_tick (
    .clk (clk),
    .rst (rst),
    .run (busy),
    .fast(fast_q),
    .tick(tick)
  );

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      mosi    <= 1'b1;
      fast_q  <= 1'b0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      bit_idx <= '0;
      rx_byte <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        fast_q  <= fast;
        tx_sh   <= tx_byte;
        mosi    <= tx_byte[7];
        bit_idx <= '0;
        sclk    <= 1'b0;
      end
    end else if (tick) begin
      if (!sclk) begin
        sclk  <= 1'b1;
        rx_sh <= {rx_sh[6:0], miso};
      end else begin
        sclk <= 1'b0;
        if (bit_idx == 3'd7) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_byte <= rx_sh;
          mosi    <= 1'b1;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          tx_sh   <= {tx_sh[6:0], 1'b0};
          mosi    <= tx_sh[6];
        end
      end
    end
  end
endmodule

// File: rtl/sd_spi_block_mover.sv
module sd_spi_block_mover
  import sd_spi_block_mover_pkg::*;
#(
  parameter int MAX_LEN    = 512,
  parameter int POLL_LIMIT = 1000,
  parameter int FAST_HALF  = 2,
  parameter int SLOW_HALF  = 8,
  localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             write_mode,
  input  logic [LEN_W-1:0] blk_len,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic [1:0]       status
);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  mover_state_e     state;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len_last;
  logic [POLL_W-1:0] poll;
  logic             is_write;
  logic             eng_start;
  logic             eng_fast;
  logic [7:0]       eng_tx;
  logic             eng_busy;
  logic             eng_done;
  logic [7:0]       eng_rx;

  spi_byte_shifter #(.FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .start  (eng_start),
    .fast   (eng_fast),
    .tx_byte(eng_tx),
    .miso   (miso),
    .sclk   (sclk),
    .mosi   (mosi),
    .busy   (eng_busy),
    .done   (eng_done),
    .rx_byte(eng_rx)
  );

  assign busy     = (state != S_IDLE);
  assign wr_ready = (state == S_WDATA);

  always_ff @(posedge clk) begin
    eng_start <= 1'b0;
    done      <= 1'b0;
    if (rst) begin
      state    <= S_IDLE;
      cnt      <= '0;
      len_last <= '0;
      poll     <= '0;
      is_write <= 1'b0;
      eng_fast <= 1'b0;
      eng_tx   <= BYTE_IDLE;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      status   <= XS_OK;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          if (blk_len == '0) begin
            done   <= 1'b1;
            status <= XS_OK;
          end else begin
            len_last  <= blk_len - 1'b1;
            is_write  <= write_mode;
            cnt       <= '0;
            poll      <= '0;
            eng_start <= 1'b1;
            eng_tx    <= BYTE_IDLE;
            eng_fast  <= 1'b0;
            state     <= write_mode ? S_PRE : S_TOKEN;
          end
        end
        S_PRE: if (eng_done) begin
          if (cnt == '0) begin
            cnt       <= 1;
            eng_start <= 1'b1;
            eng_tx    <= BYTE_START;
            eng_fast  <= 1'b0;
          end else begin
            cnt   <= '0;
            state <= S_WDATA;
          end
        end
        S_WDATA: if (wr_valid) begin
          eng_start <= 1'b1;
          eng_tx    <= wr_data;
          eng_fast  <= 1'b1;
          state     <= S_WSEND;
        end
        S_WSEND: if (eng_done) begin
          if (cnt == len_last) begin
            cnt       <= '0;
            eng_start <= 1'b1;
            eng_tx    <= BYTE_PAD;
            eng_fast  <= 1'b0;
            state     <= S_TRAIL;
          end else begin
            cnt   <= cnt + 1'b1;
            state <= S_WDATA;
          end
        end
        S_TOKEN: if (eng_done) begin
          if (eng_rx == BYTE_START) begin
            cnt       <= '0;
            eng_start <= 1'b1;
            eng_tx    <= BYTE_IDLE;
            eng_fast  <= 1'b1;
            state     <= S_RDATA;
          end else if (eng_rx != BYTE_IDLE) begin
            done   <= 1'b1;
            status <= XS_TOKEN_ERR;
            state  <= S_IDLE;
          end else if (poll == POLL_W'(POLL_LIMIT - 1)) begin
            done   <= 1'b1;
            status <= XS_TIMEOUT;
            state  <= S_IDLE;
          end else begin
            poll      <= poll + 1'b1;
            eng_start <= 1'b1;
            eng_tx    <= BYTE_IDLE;
            eng_fast  <= 1'b0;
          end
        end
        S_RDATA: if (eng_done) begin
          rd_data  <= eng_rx;
          rd_valid <= 1'b1;
          state    <= S_RHOLD;
        end
        S_RHOLD: if (rd_ready) begin
          rd_valid  <= 1'b0;
          eng_start <= 1'b1;
          eng_tx    <= BYTE_IDLE;
          if (cnt == len_last) begin
            cnt      <= '0;
            eng_fast <= 1'b0;
            state    <= S_TRAIL;
          end else begin
            cnt      <= cnt + 1'b1;
            eng_fast <= 1'b1;
            state    <= S_RDATA;
          end
        end
        S_TRAIL: if (eng_done) begin
          if (cnt == LEN_W'(TRAIL_BYTES - 1)) begin
            if (is_write) begin
              poll      <= '0;
              eng_start <= 1'b1;
              eng_tx    <= BYTE_IDLE;
              eng_fast  <= 1'b0;
              state     <= S_BUSY;
            end else begin
              done   <= 1'b1;
              status <= XS_OK;
              state  <= S_IDLE;
            end
          end else begin
            cnt       <= cnt + 1'b1;
            eng_start <= 1'b1;
            eng_tx    <= is_write ? BYTE_PAD : BYTE_IDLE;
            eng_fast  <= 1'b0;
          end
        end
        S_BUSY: if (eng_done) begin
          if (eng_rx == BYTE_IDLE) begin
            done   <= 1'b1;
            status <= XS_OK;
            state  <= S_IDLE;
          end else if (poll == POLL_W'(POLL_LIMIT - 1)) begin
            done   <= 1'b1;
            status <= XS_TIMEOUT;
            state  <= S_IDLE;
          end else begin
            poll      <= poll + 1'b1;
            eng_start <= 1'b1;
            eng_tx    <= BYTE_IDLE;
            eng_fast  <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_spi_block_mover_chk.sv
module sd_spi_block_mover_chk #(
  parameter int LEN_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             write_mode,
  input logic [LEN_W-1:0] blk_len,
  input logic [7:0]       rd_data,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic             wr_ready,
  input logic             sclk,
  input logic             mosi,
  input logic             busy,
  input logic             done,
  input logic [1:0]       status
);
  logic rd_mode;

  always_ff @(posedge clk) begin
    if (rst)                rd_mode <= 1'b0;
    else if (start && !busy) rd_mode <= !write_mode;
  end

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R6
  clk_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> $stable(sclk));

  // R11
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    start && !busy && (blk_len == '0) |=> done && (status == 2'd0) && !busy);

  // R12
  read_mosi_chk: assert property (@(posedge clk) disable iff (rst)
    busy && rd_mode |-> mosi);

  // R1
  idle_clk_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  wr_ready_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> busy && !rd_mode && !sclk);
endmodule

bind sd_spi_block_mover sd_spi_block_mover_chk #(.LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .write_mode(write_mode),
  .blk_len   (blk_len),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .wr_ready  (wr_ready),
  .sclk      (sclk),
  .mosi      (mosi),
  .busy      (busy),
  .done      (done),
  .status    (status)
);

// File: tb/sd_spi_block_mover_tb.sv
`timescale 1ns/1ps
module sd_spi_block_mover_tb;
  localparam int MAX_LEN = 512;
  localparam int POLL    = 6;
  localparam int FH      = 1;
  localparam int SH      = 3;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic clk = 0, rst = 1, start = 0, write_mode = 0;
  logic [LEN_W-1:0] blk_len = '0;
  logic [7:0] rd_data, wr_data = 8'h00;
  logic rd_valid, rd_ready = 1, wr_valid = 0, wr_ready;
  logic sclk, mosi, miso, busy, done;
  logic [1:0] status;

  always #2.5 clk = ~clk;

  sd_spi_block_mover #(.MAX_LEN(MAX_LEN), .POLL_LIMIT(POLL), .FAST_HALF(FH), .SLOW_HALF(SH)) u_dut (
    .clk(clk), .rst(rst), .start(start), .write_mode(write_mode), .blk_len(blk_len),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .sclk(sclk), .mosi(mosi), .miso(miso), .busy(busy), .done(done), .status(status));

  int n_chk = 0, n_fail = 0;
  logic [7:0] card_q [1024];
  logic [7:0] host_q [1024];
  logic [7:0] rd_q   [1024];
  int width_q [1024];
  int cidx = 0, cbit = 0, hidx = 0, rise_cnt = 0, ridx = 0, hcnt = 0, done_cnt = 0;
  logic [7:0] hsh = 0;

  assign miso = (cidx < 1024) ? card_q[cidx][7 - cbit] : 1'b1;

  always @(negedge sclk) begin
    cbit = cbit + 1;
    if (cbit == 8) begin cbit = 0; cidx = cidx + 1; end
  end
  always @(posedge sclk) begin
    hsh = {hsh[6:0], mosi};
    rise_cnt = rise_cnt + 1;
    if (rise_cnt % 8 == 0) begin host_q[hidx] = hsh; hidx = hidx + 1; end
  end
  always @(posedge clk) begin
    if (sclk) hcnt = hcnt + 1;
    else if (hcnt != 0) begin width_q[(rise_cnt - 1) / 8] = hcnt; hcnt = 0; end
  end
  always @(negedge clk) begin
    if (rd_valid && rd_ready) begin rd_q[ridx] = rd_data; ridx = ridx + 1; end
    if (done) done_cnt = done_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int len);
    return 8'((i * 7 + len + 3) & 255);
  endfunction

  // {wr, len, lead, tok, busyn, status}
  localparam logic [36:0] VEC [8] = '{
    {1'b0, 10'd4, 8'd0, 8'hFE, 8'd0, 2'd0},
    {1'b0, 10'd3, 8'd4, 8'hFE, 8'd0, 2'd0},
    {1'b0, 10'd2, 8'd5, 8'hFE, 8'd0, 2'd0},
    {1'b0, 10'd2, 8'd6, 8'hFE, 8'd0, 2'd1},
    {1'b0, 10'd2, 8'd2, 8'h3C, 8'd0, 2'd2},
    {1'b1, 10'd5, 8'd0, 8'h00, 8'd3, 2'd0},
    {1'b1, 10'd1, 8'd0, 8'h00, 8'd5, 2'd0},
    {1'b1, 10'd2, 8'd0, 8'h00, 8'd6, 2'd1}
  };

  task automatic run(input bit wr, input int len, input int lead, input logic [7:0] tok,
                     input int busyn, input int st, input bit stall, input bit poke);
    int exp_bytes, base, d0, bad;
    for (int i = 0; i < 1024; i++) card_q[i] = 8'hFF;
    if (!wr) begin
      card_q[lead] = tok;
      for (int i = 0; i < len; i++) card_q[lead + 1 + i] = pat(i, len);
      exp_bytes = (st == 0) ? lead + 1 + len + 3 : (st == 1) ? POLL : lead + 1;
    end else begin
      for (int i = 0; i < busyn && i < 1000; i++) card_q[5 + len + i] = 8'h00;
      exp_bytes = (st == 0) ? 5 + len + busyn + 1 : 5 + len + POLL;
    end
    cidx = 0; cbit = 0; hidx = 0; rise_cnt = 0; ridx = 0; hcnt = 0;
    d0 = done_cnt;
    if (stall) rd_ready = 0;
    @(negedge clk); write_mode = wr; blk_len = LEN_W'(len); start = 1;
    @(negedge clk); start = 0;
    fork
      begin
        if (wr) for (int i = 0; i < len; i++) begin
          wr_valid = 1; wr_data = pat(i, len);
          forever begin @(negedge clk); if (wr_ready) break; end
          @(posedge clk); #1 wr_valid = 0;
        end
      end
      begin while (!done) @(negedge clk); end
      begin
        if (poke) begin
          repeat (10) @(negedge clk);
          start = 1; write_mode = !wr; blk_len = '0;
          @(negedge clk); start = 0;
        end
      end
      begin
        if (stall) begin
          logic [7:0] hd; int rc;
          while (!rd_valid) @(negedge clk);
          hd = rd_data; rc = rise_cnt;
          repeat (20) @(negedge clk);
          chk(rd_valid && rd_data == hd, "R6 held byte", rd_data, hd);
          chk(rise_cnt == rc, "R6 sclk frozen", rise_cnt, rc);
          rd_ready = 1;
        end
      end
    join
    @(negedge clk);
    chk(status == 2'(st), wr ? "R8/R9 status" : "R2/R3/R4 status", status, st);
    chk(hidx == exp_bytes, wr ? "R8/R9 byte count" : "R5/R3/R4 byte count", hidx, exp_bytes);
    chk(done_cnt - d0 == 1, "R13 single done", done_cnt - d0, 1);
    if (!wr) begin
      bad = 0;
      for (int i = 0; i < hidx; i++) if (host_q[i] != 8'hFF) bad++;
      chk(bad == 0, "R12 mosi high on read", bad, 0);
      chk(ridx == ((st == 0) ? len : 0), "R2/R4 payload count", ridx, (st == 0) ? len : 0);
      bad = 0;
      if (st == 0) for (int i = 0; i < len; i++) if (rd_q[i] != pat(i, len)) bad++;
      chk(bad == 0, "R2 payload bytes", bad, 0);
      if (st == 0) begin
        chk(width_q[lead] == SH, "R10 token slow", width_q[lead], SH);
        chk(width_q[lead + 1] == FH, "R10 payload fast", width_q[lead + 1], FH);
        chk(width_q[lead + 1 + len] == SH, "R10 trailer slow", width_q[lead + 1 + len], SH);
      end
    end else begin
      bad = 0;
      if (host_q[0] != 8'hFF) bad++;
      if (host_q[1] != 8'hFE) bad++;
      for (int i = 0; i < len; i++) if (host_q[2 + i] != pat(i, len)) bad++;
      for (int i = 0; i < 3; i++) if (host_q[2 + len + i] != 8'h00) bad++;
      base = 5 + len;
      for (int i = base; i < hidx; i++) if (host_q[i] != 8'hFF) bad++;
      chk(bad == 0, "R7 write byte sequence", bad, 0);
      chk(width_q[1] == SH, "R10 write token slow", width_q[1], SH);
      chk(width_q[2] == FH, "R10 write payload fast", width_q[2], FH);
      chk(width_q[2 + len] == SH, "R10 write pad slow", width_q[2 + len], SH);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) card_q[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !sclk && mosi && !rd_valid && !wr_ready && status == 0,
        "R1 reset state", {busy, done, sclk, mosi, rd_valid, wr_ready}, 6'b000100);

    for (int v = 0; v < 8; v++)
      run(VEC[v][36], int'(VEC[v][35:26]), int'(VEC[v][25:18]), VEC[v][17:10],
          int'(VEC[v][9:2]), int'(VEC[v][1:0]), 1'b0, 1'b0);

    // R11 zero length
    rise_cnt = 0;
    @(negedge clk); write_mode = 0; blk_len = '0; start = 1;
    @(negedge clk); start = 0;
    chk(done && status == 0 && !busy, "R11 zero length done", {done, status}, 3'b100);
    repeat (5) @(negedge clk);
    chk(rise_cnt == 0, "R11 no sclk", rise_cnt, 0);

    // R6 backpressure
    run(1'b0, 4, 1, 8'hFE, 0, 0, 1'b1, 1'b0);
    // R13 start during busy ignored
    run(1'b0, 3, 2, 8'hFE, 0, 0, 1'b0, 1'b1);
    // R12 maximum length
    run(1'b0, MAX_LEN, 0, 8'hFE, 0, 0, 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule